// File: doc/BRIEF.md
# External Data Access Router

This block serves the byte-wide external-data move of an 8051-style core. Each request carries a direction, an address-source flag and an address. The source is either an 8-bit register pointer or a 16-bit data pointer. A routing mode bit, together with the address, decides where the request goes. It can stay inside the block on a 256-byte auxiliary RAM, or it can run as a cycle on a multiplexed external bus. On that bus the low address byte and the data share one port, and an address latch enable marks when the address is valid.

Auxiliary RAM accesses complete in one clock and leave every external pin alone. External accesses step through fixed phases:
1. The address is driven with the latch enable high.
2. A hold clock follows with the latch enable low.
3. An active-low strobe stays low for a set number of clocks.
4. The bus is released.

The core waits for the one-clock done pulse. On a read it then takes the byte from the read data output.

Top module: `xdata_router`

## Requirements
- R1: With `ext_only`=0 and `req_wide`=0 (8-bit pointer), a request accesses the auxiliary RAM at `req_addr[7:0]`, and `rsp_done` is high in the clock right after the accepting edge. For a read, `rsp_rdata` holds the stored byte in that same clock.
- R2: With `ext_only`=0 and `req_wide`=1, addresses 0x0000–0x00FF go to the auxiliary RAM and addresses 0x0100–0xFFFF go to the external bus.
- R3: An auxiliary-RAM access changes none of `bus_ad_o`, `bus_ad_oe`, `bus_hi`, `bus_ale`, `bus_wr_n` or `bus_rd_n`.
- R4: With `ext_only`=1, every request runs an external cycle and the auxiliary RAM contents are left unchanged.
- R5: An external 8-bit-pointer access drives `req_addr[7:0]` on `bus_ad_o` while `bus_ale` is high, and `bus_hi` keeps its previous value.
- R6: An external 16-bit-pointer access drives `req_addr[15:8]` on `bus_hi` and `req_addr[7:0]` on `bus_ad_o` while `bus_ale` is high.
- R7: An external cycle runs in this order:
  - `bus_ale` is high for exactly 1 clock, then there is 1 hold clock.
  - The strobe is low for STROBE_CYCLES clocks.
  - `rsp_done` pulses in the clock the strobe returns high, which is STROBE_CYCLES+3 clocks after the request is presented.
- R8: On an external write, `bus_wr_n` goes low and `req_wdata` is driven on `bus_ad_o` with `bus_ad_oe`=1. On an external read, `bus_rd_n` goes low, and `bus_ad_i` is sampled at the edge where `bus_rd_n` rises and returned on `rsp_rdata`.
- R9: `bus_ad_oe` is 0 whenever neither an address nor write data is driven, including the whole read-strobe phase. `bus_wr_n` and `bus_rd_n` are never low together, and neither is low while `bus_ale` is high.
- R10: A request presented while an external cycle is in progress is ignored. A write presented then does not reach the auxiliary RAM.
- R11: After reset, `bus_ale`=0, `bus_wr_n`=1, `bus_rd_n`=1, `bus_ad_oe`=0, `bus_hi`=0 and `rsp_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted when no external cycle is running |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data pointer, 0 = 8-bit register pointer |
| req_addr | input | ADDR_W | Access address (low byte only for the 8-bit pointer) |
| req_wdata | input | DATA_W | Write data |
| ext_only | input | 1 | Routing mode: 1 = all accesses external, 0 = low 256 bytes internal |
| rsp_rdata | output | DATA_W | Read data, valid while rsp_done is high |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_ad_o | output | DATA_W | Multiplexed address/data port, output value |
| bus_ad_oe | output | 1 | Output enable of the multiplexed port |
| bus_ad_i | input | DATA_W | Multiplexed port, input value |
| bus_hi | output | ADDR_W-DATA_W | High address byte port |
| bus_ale | output | 1 | Address latch enable |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_rd_n | output | 1 | Active-low read strobe |

## Verification
The bench builds the block with the default 8-bit data and 16-bit address, and with STROBE_CYCLES set to 2. This keeps each external cycle at five clocks. All 256 auxiliary RAM locations are written through the 8-bit pointer and read back through both pointer kinds, with the pin state watched for any change. External cycles are then placed on both sides of the 0x00FF/0x0100 boundary in both routing modes. A simple bus model latches the address and answers reads with a byte computed from it. The bench counts clocks with the latch enable high and with the strobe low, checks that the high port is kept on 8-bit-pointer cycles, and checks that a write presented mid-cycle is dropped.

// File: rtl/xdr_pkg.sv
package xdr_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_HOLD = 2'd2,
    SQ_STRB = 2'd3
  } seq_state_e;
endpackage

// File: rtl/xdr_aux_ram.sv
module xdr_aux_ram #(
  parameter int DATA_W = 8,
  parameter int AW     = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single port, inferable as block RAM
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/xdr_route_decode.sv
module xdr_route_decode #(
  parameter int ADDR_W = 16,
  parameter int AUX_AW = 8
) (
  input  logic              ext_only,
  input  logic              wide,
  input  logic [ADDR_W-1:0] addr,
  output logic              to_aux,
  output logic [AUX_AW-1:0] aux_addr
);
  localparam int UPPER_W = ADDR_W - AUX_AW;

  logic upper_zero;

  assign upper_zero = (addr[ADDR_W-1:AUX_AW] == {UPPER_W{1'b0}});
  assign to_aux     = !ext_only && (!wide || upper_zero);
  assign aux_addr   = addr[AUX_AW-1:0];
endmodule

// File: rtl/xdr_bus_seq.sv
module xdr_bus_seq
  import xdr_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 16,
  parameter int STROBE_CYCLES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     is_write,
  input  logic                     wide,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdata,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  output logic [ADDR_W-DATA_W-1:0] bus_hi,
  output logic                     bus_ale,
  output logic                     bus_wr_n,
  output logic                     bus_rd_n
);
  localparam int CNT_W = (STROBE_CYCLES < 2) ? 1 : $clog2(STROBE_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYCLES - 1);

  seq_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [DATA_W-1:0] wd_q;

  assign busy = (state != SQ_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      wd_q      <= '0;
      done      <= 1'b0;
      rdata     <= '0;
      bus_ad_o  <= '0;
      bus_ad_oe <= 1'b0;
      bus_hi    <= '0;
      bus_ale   <= 1'b0;
      bus_wr_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
    end else begin
      done <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (start) begin
            bus_ale   <= 1'b1;
            bus_ad_oe <= 1'b1;
            bus_ad_o  <= addr[DATA_W-1:0];
            if (wide) bus_hi <= addr[ADDR_W-1:DATA_W];
            wr_q      <= is_write;
            wd_q      <= wdata;
            state     <= SQ_ADDR;
          end
        end
        SQ_ADDR: begin
          bus_ale <= 1'b0;
          state   <= SQ_HOLD;
        end
        SQ_HOLD: begin
          cnt   <= '0;
          state <= SQ_STRB;
          if (wr_q) begin
            bus_wr_n  <= 1'b0;
            bus_ad_o  <= wd_q;
            bus_ad_oe <= 1'b1;
          end else begin
            bus_rd_n  <= 1'b0;
            bus_ad_oe <= 1'b0;
          end
        end
        SQ_STRB: begin
          if (cnt == CNT_LAST) begin
            bus_wr_n  <= 1'b1;
            bus_rd_n  <= 1'b1;
            bus_ad_oe <= 1'b0;
            done      <= 1'b1;
            state     <= SQ_IDLE;
            if (!wr_q) rdata <= bus_ad_i;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 16,
  parameter int AUX_AW        = 8,
  parameter int STROBE_CYCLES = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_wide,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic                     ext_only,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic                     rsp_done,
  output logic [DATA_W-1:0]        bus_ad_o,
  output logic                     bus_ad_oe,
  input  logic [DATA_W-1:0]        bus_ad_i,
  output logic [ADDR_W-DATA_W-1:0] bus_hi,
  output logic                     bus_ale,
  output logic                     bus_wr_n,
  output logic                     bus_rd_n
);
  logic              seq_busy;
  logic              seq_done;
  logic [DATA_W-1:0] seq_rdata;
  logic              route_aux;
  logic [AUX_AW-1:0] aux_addr;
  logic [DATA_W-1:0] aux_rdata;
  logic              accept;
  logic              go_aux;
  logic              go_ext;
  logic              aux_done_q;
  logic              sel_aux_q;

  assign accept = req_valid && !seq_busy;
  assign go_aux = accept && route_aux;
  assign go_ext = accept && !route_aux;

  xdr_route_decode #(.ADDR_W(ADDR_W), .AUX_AW(AUX_AW)) u_dec (
    .ext_only (ext_only),
    .wide     (req_wide),
    .addr     (req_addr),
    .to_aux   (route_aux),
    .aux_addr (aux_addr)
  );

  xdr_aux_ram #(.DATA_W(DATA_W), .AW(AUX_AW)) u_ram (
    .clk   (clk),
    .en    (go_aux),
    .we    (req_write),
    .addr  (aux_addr),
    .wdata (req_wdata),
    .rdata (aux_rdata)
  );

  xdr_bus_seq #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STROBE_CYCLES(STROBE_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (go_ext),
    .is_write  (req_write),
    .wide      (req_wide),
    .addr      (req_addr),
    .wdata     (req_wdata),
    .bus_ad_i  (bus_ad_i),
    .busy      (seq_busy),
    .done      (seq_done),
    .rdata     (seq_rdata),
    .bus_ad_o  (bus_ad_o),
    .bus_ad_oe (bus_ad_oe),
    .bus_hi    (bus_hi),
    .bus_ale   (bus_ale),
    .bus_wr_n  (bus_wr_n),
    .bus_rd_n  (bus_rd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      aux_done_q <= 1'b0;
      sel_aux_q  <= 1'b0;
    end else begin
      aux_done_q <= go_aux;
      if (accept) sel_aux_q <= route_aux;
    end
  end

  assign rsp_done  = aux_done_q | seq_done;
  assign rsp_rdata = sel_aux_q ? aux_rdata : seq_rdata;
endmodule

// File: rtl/xdr_checker.sv
module xdr_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 16,
  parameter int AUX_AW = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     req_valid,
  input logic                     req_wide,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     ext_only,
  input logic                     busy,
  input logic                     rsp_done,
  input logic [DATA_W-1:0]        bus_ad_o,
  input logic                     bus_ad_oe,
  input logic [ADDR_W-DATA_W-1:0] bus_hi,
  input logic                     bus_ale,
  input logic                     bus_wr_n,
  input logic                     bus_rd_n
);
  logic acc_int;
  logic acc_ext;
  assign acc_int = req_valid && !busy && !ext_only &&
                   (!req_wide || req_addr[ADDR_W-1:AUX_AW] == '0);
  assign acc_ext = req_valid && !busy && !acc_int;

  // R3
  aux_pins_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    acc_int |=> $stable(bus_ad_o) && $stable(bus_ad_oe) && $stable(bus_hi) &&
                $stable(bus_ale) && $stable(bus_wr_n) && $stable(bus_rd_n));

  // R1
  aux_done_chk: assert property (@(posedge clk) disable iff (rst)
    acc_int |=> rsp_done);

  // R5
  narrow_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ext && !req_wide) |=> $stable(bus_hi) && bus_ale);

  // R6
  wide_drives_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ext && req_wide) |=> bus_ale && bus_hi == $past(req_addr[ADDR_W-1:DATA_W])
                              && bus_ad_o == $past(req_addr[DATA_W-1:0]));

  // R9
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(!bus_wr_n && !bus_rd_n) && !(bus_ale && (!bus_wr_n || !bus_rd_n)));

  // R8
  write_drives_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_wr_n |-> bus_ad_oe);

  // R9
  read_releases_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_n |-> !bus_ad_oe);

  // R7
  done_on_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_rd_n) || $rose(bus_wr_n)) |-> rsp_done && !bus_ad_oe);

  // R7
  ale_one_clock_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ale |=> !bus_ale);
endmodule

bind xdata_router xdr_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AUX_AW(AUX_AW)
) u_xdr_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_wide  (req_wide),
  .req_addr  (req_addr),
  .ext_only  (ext_only),
  .busy      (seq_busy),
  .rsp_done  (rsp_done),
  .bus_ad_o  (bus_ad_o),
  .bus_ad_oe (bus_ad_oe),
  .bus_hi    (bus_hi),
  .bus_ale   (bus_ale),
  .bus_wr_n  (bus_wr_n),
  .bus_rd_n  (bus_rd_n)
);

// File: tb/xdata_router_bench.sv
`timescale 1ns/1ps
module xdata_router_bench;
  localparam int S = 2;
  localparam int EXT_CYC = S + 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0, ext_only = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [7:0]  rsp_rdata, bus_ad_o, bus_ad_i, bus_hi;
  logic        rsp_done, bus_ad_oe, bus_ale, bus_wr_n, bus_rd_n;

  int n_checks = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  xdata_router #(.STROBE_CYCLES(S)) u_xdata_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .ext_only(ext_only), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
    .bus_ad_o(bus_ad_o), .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i),
    .bus_hi(bus_hi), .bus_ale(bus_ale), .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n)
  );

  // external bus model
  logic [15:0] lat_addr = '0;
  logic [7:0]  wr_seen = '0;
  int          ale_cnt = 0, wr_cnt = 0, rd_cnt = 0, pin_events = 0, wr_oe_bad = 0;
  logic [29:0] pin_prev = '0;

  function automatic logic [7:0] ext_val(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hC3;
  endfunction

  function automatic logic [7:0] aux_val(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  assign bus_ad_i = ext_val(lat_addr);

  always @(negedge clk) begin
    if (bus_ale) begin
      lat_addr <= {bus_hi, bus_ad_o};
      ale_cnt  <= ale_cnt + 1;
    end
    if (!bus_wr_n) begin
      wr_cnt  <= wr_cnt + 1;
      wr_seen <= bus_ad_o;
      if (!bus_ad_oe) wr_oe_bad <= wr_oe_bad + 1;
    end
    if (!bus_rd_n) rd_cnt <= rd_cnt + 1;
    if ({bus_ad_o, bus_ad_oe, bus_hi, bus_ale, bus_wr_n, bus_rd_n} != pin_prev[20:0])
      pin_events <= pin_events + 1;
    pin_prev <= {9'd0, bus_ad_o, bus_ad_oe, bus_hi, bus_ale, bus_wr_n, bus_rd_n};
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk);
    ale_cnt = 0; wr_cnt = 0; rd_cnt = 0; wr_oe_bad = 0;
  endtask

  task automatic xfer(input logic w, input logic wide, input logic md,
                      input logic [15:0] a, input logic [7:0] d,
                      output logic [7:0] rd, output int cyc);
    req_valid = 1'b1; req_write = w; req_wide = wide; ext_only = md;
    req_addr = a; req_wdata = d;
    cyc = 0;
    for (int k = 0; k < 50; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (rsp_done) break;
    end
    rd = rsp_rdata;
  endtask

  logic [7:0] rd;
  int cyc, ev0;
  bit finished = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 ale", bus_ale, 0);
    chk("R11 wr_n", bus_wr_n, 1);
    chk("R11 rd_n", bus_rd_n, 1);
    chk("R11 oe", bus_ad_oe, 0);
    chk("R11 hi", bus_hi, 0);
    chk("R11 done", rsp_done, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R3: fill all aux locations through the 8-bit pointer
    for (int a = 0; a < 256; a++) begin
      ev0 = pin_events;
      xfer(1'b1, 1'b0, 1'b0, 16'(a) | 16'hAB00, aux_val(a), rd, cyc);
      chk("R1 aux write latency", cyc, 1);
      @(negedge clk);
      chk("R3 pins unchanged on aux write", pin_events, ev0);
    end
    // read back: even via wide pointer (R2 low range), odd via narrow (R1)
    for (int a = 0; a < 256; a++) begin
      ev0 = pin_events;
      if (a % 2 == 0) begin
        xfer(1'b0, 1'b1, 1'b0, 16'(a), 8'h00, rd, cyc);
        chk("R2 wide low-range reads aux", rd, aux_val(a));
      end else begin
        xfer(1'b0, 1'b0, 1'b0, 16'(a), 8'h00, rd, cyc);
        chk("R1 narrow reads aux", rd, aux_val(a));
      end
      chk("R1 aux read latency", cyc, 1);
      chk("R3 pins unchanged on aux read", pin_events, ev0);
    end

    // R2 / R6 / R7 / R8: wide pointer at 0x0100 in mode 0 is external read
    clear_mon();
    xfer(1'b0, 1'b1, 1'b0, 16'h0100, 8'h00, rd, cyc);
    chk("R2 0x0100 goes external", ale_cnt, 1);
    chk("R6 latched address", lat_addr, 16'h0100);
    chk("R7 ext read latency", cyc, EXT_CYC);
    chk("R7 read strobe width", rd_cnt, S);
    chk("R8 read data sampled", rd, ext_val(16'h0100));
    chk("R9 oe released after cycle", bus_ad_oe, 0);

    // R6 / R8: external write to 0xFFFF and 0x5A3C
    foreach (lat_addr[i]) begin end
    for (int t = 0; t < 2; t++) begin
      logic [15:0] ea;
      logic [7:0]  ed;
      ea = (t == 0) ? 16'hFFFF : 16'h5A3C;
      ed = (t == 0) ? 8'h96 : 8'h3E;
      clear_mon();
      xfer(1'b1, 1'b1, 1'b0, ea, ed, rd, cyc);
      chk("R6 wide ext address", lat_addr, ea);
      chk("R8 write data on bus", wr_seen, ed);
      chk("R8 write strobe width", wr_cnt, S);
      chk("R8 oe during write strobe", wr_oe_bad, 0);
      chk("R7 ext write latency", cyc, EXT_CYC);
      chk("R7 ale one clock", ale_cnt, 1);
    end

    // R5: narrow external access in mode 1 keeps high byte 0x5A
    clear_mon();
    xfer(1'b0, 1'b0, 1'b1, 16'hEE77, 8'h00, rd, cyc);
    chk("R5 hi kept, low from pointer", lat_addr, 16'h5A77);
    chk("R5 narrow ext read data", rd, ext_val(16'h5A77));
    chk("R5 hi port value", bus_hi, 8'h5A);

    // R4: mode 1 wide write into low range stays off the aux RAM
    clear_mon();
    xfer(1'b1, 1'b1, 1'b1, 16'h0042, 8'hF0, rd, cyc);
    chk("R4 mode1 low address external", ale_cnt, 1);
    chk("R4 mode1 ext write data", wr_seen, 8'hF0);
    xfer(1'b0, 1'b0, 1'b0, 16'h0042, 8'h00, rd, cyc);
    chk("R4 aux untouched by mode1 write", rd, aux_val(8'h42));

    // R2 boundary: 0x00FF wide in mode 0 is internal
    ev0 = pin_events;
    xfer(1'b0, 1'b1, 1'b0, 16'h00FF, 8'h00, rd, cyc);
    chk("R2 0x00FF internal", rd, aux_val(255));
    chk("R2 0x00FF pins quiet", pin_events, ev0);

    // R10: aux write presented during an external cycle is dropped
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b1; ext_only = 1'b0;
    req_addr = 16'h1234;
    @(negedge clk);
    req_write = 1'b1; req_wide = 1'b0; req_addr = 16'h0033; req_wdata = 8'hEE;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    for (int k = 0; k < 50; k++) begin
      if (rsp_done) break;
      @(negedge clk);
      cyc++;
    end
    chk("R10 external cycle completes", rsp_done, 1);
    chk("R10 ext read data", rsp_rdata, ext_val(16'h1234));
    @(negedge clk);
    xfer(1'b0, 1'b0, 1'b0, 16'h0033, 8'h00, rd, cyc);
    chk("R10 busy-time write ignored", rd, aux_val(8'h33));

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule